// File: doc/BRIEF.md
# Shared Mailbox with Ownership Handoff

This block is a 256-bit mailbox shared by two agents, a requester and a responder. It holds eight 32-bit dwords. Each side has its own write port and its own combinational read port, so both can see the same storage. The last dword is a control header. Its top bit records which side currently owns the mailbox.

A transaction runs as follows. While it owns the mailbox, the requester fills the payload dwords and then writes the header. Writing the header hands ownership to the responder. The responder may then change any dword. It returns the mailbox by writing a header that carries the response direction bit. Every handoff raises a one-cycle pulse. While the requester is held in reset, the requester's view of the header reads as all ones, so the requester can recognise that state.

Top module: `shm_mailbox`

## Requirements
- R1: After reset every dword reads 0 on both read ports, `owner_is_rsp` is 0 (the requester owns the mailbox) and `handoff_pulse` is 0.
- R2: An accepted write stores its data in the dword selected by its index. From the next cycle the value is visible on both read ports.
- R3: A requester write to dword 7 is stored with bit 31 forced to 1, and from the next cycle `owner_is_rsp` is 1. Writes to dwords 0 to 6 never change ownership.
- R4: A responder write to dword 7 with bit 7 (direction) set to 1 is stored with bit 31 forced to 0, and ownership returns to the requester. With bit 7 set to 0, the write is stored with bit 31 held at 1, and ownership does not change.
- R5: Requester writes have no effect while the responder owns the mailbox. Responder writes have no effect while the requester owns it.
- R6: While `req_in_reset` is 1, a requester read of dword 7 returns 0xFFFFFFFF. Requester reads of other dwords and all responder reads are unaffected.
- R7: `handoff_pulse` is 1 for exactly the one cycle that follows each ownership change, and is 0 in all other cycles.
- R8: The header fields are stored as written, apart from bit 31. These fields are type (bits 2:0), version (bits 5:3), direction (bit 7), status (bits 15:8) and the reset flag (bit 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in_reset | input | 1 | Requester is in reset |
| req_wr_en | input | 1 | Requester write strobe |
| req_wr_idx | input | 3 | Requester write dword index |
| req_wr_data | input | 32 | Requester write data |
| req_rd_idx | input | 3 | Requester read dword index |
| req_rd_data | output | 32 | Requester read data |
| rsp_wr_en | input | 1 | Responder write strobe |
| rsp_wr_idx | input | 3 | Responder write dword index |
| rsp_wr_data | input | 32 | Responder write data |
| rsp_rd_idx | input | 3 | Responder read dword index |
| rsp_rd_data | output | 32 | Responder read data |
| owner_is_rsp | output | 1 | 1 while the responder owns the mailbox |
| handoff_pulse | output | 1 | One-cycle pulse after each ownership change |

## Verification
The hardest case to reach is a responder header write with the direction bit clear. To reach it, the mailbox must first be handed over by a requester header write. The stimulus then checks that the header is stored while ownership stays put and no pulse appears. The bench also issues writes from the side that does not own the mailbox, in both ownership states. It then reads the targeted dwords back to show they did not change. Finally, the reset-read view is checked while the responder port reads the real header in the same cycle.

// File: rtl/shm_mailbox.sv
module shm_mailbox #(
  parameter int DWORDS  = 8,
  parameter int DW      = 32,
  parameter int OWN_BIT = 31,
  parameter int DIR_BIT = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_in_reset,
  input  logic                      req_wr_en,
  input  logic [$clog2(DWORDS)-1:0] req_wr_idx,
  input  logic [DW-1:0]             req_wr_data,
  input  logic [$clog2(DWORDS)-1:0] req_rd_idx,
  output logic [DW-1:0]             req_rd_data,
  input  logic                      rsp_wr_en,
  input  logic [$clog2(DWORDS)-1:0] rsp_wr_idx,
  input  logic [DW-1:0]             rsp_wr_data,
  input  logic [$clog2(DWORDS)-1:0] rsp_rd_idx,
  output logic [DW-1:0]             rsp_rd_data,
  output logic                      owner_is_rsp,
  output logic                      handoff_pulse
);
  localparam int IDX_W = $clog2(DWORDS);
  localparam int HDR   = DWORDS - 1;
  localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_BIT;

  logic [DW-1:0] mem [DWORDS];

  assign owner_is_rsp = mem[HDR][OWN_BIT];

  wire req_acc = req_wr_en & ~owner_is_rsp;
  wire rsp_acc = rsp_wr_en &  owner_is_rsp;
  wire req_hdr = req_acc & (req_wr_idx == IDX_W'(HDR));
  wire rsp_hdr = rsp_acc & (rsp_wr_idx == IDX_W'(HDR));
  wire rsp_ret = rsp_hdr & rsp_wr_data[DIR_BIT];

  for (genvar i = 0; i < DWORDS; i++) begin : g_dw
    if (i == HDR) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          mem[i] <= '0;
        else if (req_hdr)
          mem[i] <= req_wr_data | OWN_MASK;
        else if (rsp_hdr)
          mem[i] <= rsp_ret ? (rsp_wr_data & ~OWN_MASK) : (rsp_wr_data | OWN_MASK);
    end else begin : g_pay
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          mem[i] <= '0;
        else if (req_acc && req_wr_idx == IDX_W'(i))
          mem[i] <= req_wr_data;
        else if (rsp_acc && rsp_wr_idx == IDX_W'(i))
          mem[i] <= rsp_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) handoff_pulse <= 1'b0;
    else        handoff_pulse <= req_hdr | rsp_ret;

  assign req_rd_data = (req_in_reset && req_rd_idx == IDX_W'(HDR)) ? '1 : mem[req_rd_idx];
  assign rsp_rd_data = mem[rsp_rd_idx];
endmodule

module shm_mailbox_chk #(
  parameter int IDX_W   = 3,
  parameter int DW      = 32,
  parameter int HDR     = 7,
  parameter int DIR_BIT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_in_reset,
  input logic             req_wr_en,
  input logic [IDX_W-1:0] req_wr_idx,
  input logic [IDX_W-1:0] req_rd_idx,
  input logic [DW-1:0]    req_rd_data,
  input logic             rsp_wr_en,
  input logic [IDX_W-1:0] rsp_wr_idx,
  input logic [DW-1:0]    rsp_wr_data,
  input logic             owner_is_rsp,
  input logic             handoff_pulse
);
  AST_REQ_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_is_rsp && req_wr_en && req_wr_idx == IDX_W'(HDR)) |=> owner_is_rsp); // R3
  AST_RSP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_is_rsp && rsp_wr_en && rsp_wr_idx == IDX_W'(HDR) && rsp_wr_data[DIR_BIT]) |=> !owner_is_rsp); // R4
  AST_RSP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_is_rsp && !(rsp_wr_en && rsp_wr_idx == IDX_W'(HDR) && rsp_wr_data[DIR_BIT])) |=> owner_is_rsp); // R5
  AST_REQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_is_rsp && !(req_wr_en && req_wr_idx == IDX_W'(HDR))) |=> !owner_is_rsp); // R3
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(owner_is_rsp) |-> handoff_pulse); // R7
  AST_PULSE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(owner_is_rsp) |-> !handoff_pulse); // R7
  AST_RESET_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in_reset && req_rd_idx == IDX_W'(HDR)) |-> req_rd_data == '1); // R6
endmodule

bind shm_mailbox shm_mailbox_chk #(
  .IDX_W(IDX_W), .DW(DW), .HDR(HDR), .DIR_BIT(DIR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in_reset(req_in_reset),
  .req_wr_en(req_wr_en), .req_wr_idx(req_wr_idx), .req_rd_idx(req_rd_idx),
  .req_rd_data(req_rd_data), .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx),
  .rsp_wr_data(rsp_wr_data), .owner_is_rsp(owner_is_rsp), .handoff_pulse(handoff_pulse)
);

// File: tb/sim_shm_mailbox.sv
module sim_shm_mailbox;
  logic clk = 0, rst_n = 0, req_in_reset = 0;
  logic req_wr_en = 0, rsp_wr_en = 0;
  logic [2:0] req_wr_idx = 0, req_rd_idx = 0, rsp_wr_idx = 0, rsp_rd_idx = 0;
  logic [31:0] req_wr_data = 0, rsp_wr_data = 0, req_rd_data, rsp_rd_data;
  logic owner_is_rsp, handoff_pulse;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  shm_mailbox u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic req_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); req_wr_en = 1; req_wr_idx = idx; req_wr_data = d;
    @(negedge clk); req_wr_en = 0;
  endtask

  task automatic rsp_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); rsp_wr_en = 1; rsp_wr_idx = idx; rsp_wr_data = d;
    @(negedge clk); rsp_wr_en = 0;
  endtask

  task automatic both_rd(input logic [2:0] idx, input logic [31:0] exp, input string req);
    req_rd_idx = idx; rsp_rd_idx = idx; #1;
    chk({req, " req view"}, req_rd_data, exp);
    chk({req, " rsp view"}, rsp_rd_data, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) both_rd(3'(i), 32'h0, "R1");
    chk("R1 owner", 32'(owner_is_rsp), 0);
    chk("R1 pulse", 32'(handoff_pulse), 0);
  endtask

  task automatic t_payload;
    for (int i = 0; i < 7; i++) begin
      req_wr(3'(i), 32'hA5000000 + 32'(i * 17));
      chk("R3 no handoff on payload", 32'(owner_is_rsp), 0);
      chk("R7 no pulse on payload", 32'(handoff_pulse), 0);
    end
    for (int i = 0; i < 7; i++) both_rd(3'(i), 32'hA5000000 + 32'(i * 17), "R2");
  endtask

  task automatic t_rsp_gated;
    rsp_wr(3'd2, 32'hDEADBEEF);
    rsp_wr(3'd7, 32'h00000080);
    both_rd(3'd2, 32'hA5000022, "R5 rsp ignored");
    both_rd(3'd7, 32'h0, "R5 rsp hdr ignored");
    chk("R5 owner", 32'(owner_is_rsp), 0);
  endtask

  task automatic t_handoff;
    req_wr(3'd7, 32'h0100002A);
    chk("R3 owner", 32'(owner_is_rsp), 1);
    chk("R7 pulse high", 32'(handoff_pulse), 1);
    both_rd(3'd7, 32'h8100002A, "R8 header stored");
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(handoff_pulse), 0);
  endtask

  task automatic t_req_gated;
    req_wr(3'd1, 32'h12345678);
    req_wr(3'd7, 32'h00000003);
    both_rd(3'd1, 32'hA5000011, "R5 req ignored");
    both_rd(3'd7, 32'h8100002A, "R5 req hdr ignored");
    chk("R5 owner kept", 32'(owner_is_rsp), 1);
  endtask

  task automatic t_rsp_nodir;
    rsp_wr(3'd7, 32'h00000301);
    chk("R4 dir0 keeps owner", 32'(owner_is_rsp), 1);
    chk("R4 dir0 no pulse", 32'(handoff_pulse), 0);
    both_rd(3'd7, 32'h80000301, "R4 dir0 stored");
    rsp_wr(3'd4, 32'hCAFEF00D);
    both_rd(3'd4, 32'hCAFEF00D, "R2 rsp write");
  endtask

  task automatic t_return;
    rsp_wr(3'd7, 32'h80000582);
    chk("R4 returned", 32'(owner_is_rsp), 0);
    chk("R7 return pulse", 32'(handoff_pulse), 1);
    both_rd(3'd7, 32'h00000582, "R4 dir1 stored");
    @(negedge clk);
    chk("R7 return pulse ends", 32'(handoff_pulse), 0);
  endtask

  task automatic t_reset_view;
    req_in_reset = 1;
    req_rd_idx = 3'd7; rsp_rd_idx = 3'd7; #1;
    chk("R6 req hdr all ones", req_rd_data, 32'hFFFFFFFF);
    chk("R6 rsp hdr real", rsp_rd_data, 32'h00000582);
    req_rd_idx = 3'd4; #1;
    chk("R6 req payload real", req_rd_data, 32'hCAFEF00D);
    req_in_reset = 0; req_rd_idx = 3'd7; #1;
    chk("R6 req hdr after reset", req_rd_data, 32'h00000582);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_payload;
    t_rsp_gated;
    t_handoff;
    t_req_gated;
    t_rsp_nodir;
    t_return;
    t_reset_view;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule